// File: doc/BRIEF.md
# SIMD Bit-Plane Processor Grid

A rectangular grid of identical one-bit processing elements driven in lock step by a single broadcast instruction. Each element owns a small bank of one-bit registers and an activity flag. On every clock edge, every active element applies the same operation: a Boolean function of its own registers, or a copy of one register taken from one of its four adjacent elements. Elements whose flag is clear keep their state. This gives conditional execution across the whole image-shaped array.

A controller issues one instruction per cycle. A load port writes one row of one register plane per cycle, so a full bit-plane image takes one cycle per row. A read port returns one row of a chosen plane, and the flag plane can be selected like any other plane. Reads are combinational from the stored state.

Top module: `bitplane_grid`

## Requirements
- R1: While reset is held, and after its release, every register bit of every element reads 0 and every activity flag reads 1.
- R2: With `load_en` high, the bits of `load_data` are written into plane `load_reg` of row `load_row` at the clock edge, with bit c going to column c. Where a load and a broadcast instruction target the same bit in the same cycle, the load wins. A load with `load_reg` at or above 13 changes nothing.
- R3: `rd_data` shows row `rd_row` of plane `rd_reg` combinationally. Index 0 to 12 selects a register plane, index 13 selects the flag plane, and indices 14 and 15 read all zeros.
- R4: The instruction is packed as op[17:14], dst[13:10], srca[9:6], srcb[5:2], dir[1:0]. Opcodes 1 to 5 write dst of every active element with srca (copy), NOT srca, srca AND srcb, srca OR srcb, or srca XOR srcb, respectively. The result is visible after the next edge.
- R5: Opcode 6 writes dst with the srca bit of the adjacent element named by dir: 0 = the element one row up, 1 = one row down, 2 = one column right, 3 = one column left. A neighbour outside the grid supplies 0.
- R6: A neighbour read sees the register values held before the edge, so a shift whose dst equals its srca moves the plane by exactly one element per instruction.
- R7: An element whose flag is 0 keeps all its registers under opcodes 1 to 6.
- R8: Opcode 7 loads the flag of each active element from its srca bit. An inactive element stays inactive.
- R9: Opcode 8 sets every flag to 1, whatever the flags held before.
- R10: When `instr_valid` is low, or the opcode is 0 or above 8, or opcodes 1 to 6 name a dst at or above 13, the grid state is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| instr_valid | input | 1 | Broadcast instruction present this cycle |
| instr | input | 18 | Broadcast instruction word |
| load_en | input | 1 | Row load strobe |
| load_row | input | 4 | Row to load |
| load_reg | input | 4 | Register plane to load |
| load_data | input | 16 | Row bits, bit c for column c |
| rd_reg | input | 4 | Plane to read (13 = flags) |
| rd_row | input | 4 | Row to read |
| rd_data | output | 16 | Selected row of the selected plane |

## Verification
Every instruction and every load takes effect at the first rising edge that samples it. Its result can therefore be seen on `rd_data` from just after that edge. Reads add no latency, because the read port is combinational.

The bench applies one stimulus, advances one edge and updates its model at that edge. It then holds the inputs idle while it walks the read port over every plane and row, one unit of time apart. Because the state cannot move during that walk, each comparison is tied to the single edge that caused it.

Reset is checked both while it is held and after the two-edge synchronous release has finished.

// File: rtl/bpg_pkg.sv
package bpg_pkg;
  localparam int IDX_W   = 4;
  localparam int INSTR_W = 18;

  typedef enum logic [3:0] {
    OP_NOP    = 4'd0,
    OP_COPY   = 4'd1,
    OP_NOT    = 4'd2,
    OP_AND    = 4'd3,
    OP_OR     = 4'd4,
    OP_XOR    = 4'd5,
    OP_SHIFT  = 4'd6,
    OP_FLAGLD = 4'd7,
    OP_SETALL = 4'd8
  } op_e;

  typedef enum logic [1:0] {
    DIR_N = 2'd0,
    DIR_S = 2'd1,
    DIR_E = 2'd2,
    DIR_W = 2'd3
  } dir_e;

  typedef struct packed {
    op_e              op;
    logic [IDX_W-1:0] dst;
    logic [IDX_W-1:0] src_a;
    logic [IDX_W-1:0] src_b;
    dir_e             dir;
  } ctrl_t;
endpackage

// File: rtl/bpg_decode.sv
module bpg_decode
  import bpg_pkg::*;
#(
  parameter int NREG = 13
) (
  input  logic               valid,
  input  logic [INSTR_W-1:0] instr,
  output ctrl_t              ctrl
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NREG - 1);

  logic [3:0] opc;
  logic       dst_ok;

  assign opc    = instr[17:14];
  assign dst_ok = (instr[13:10] <= LAST);

  always_comb begin
    ctrl.dst   = instr[13:10];
    ctrl.src_a = instr[9:6];
    ctrl.src_b = instr[5:2];
    ctrl.dir   = dir_e'(instr[1:0]);
    ctrl.op    = OP_NOP;
    if (valid) begin
      case (opc)
        4'd1: ctrl.op = dst_ok ? OP_COPY  : OP_NOP;
        4'd2: ctrl.op = dst_ok ? OP_NOT   : OP_NOP;
        4'd3: ctrl.op = dst_ok ? OP_AND   : OP_NOP;
        4'd4: ctrl.op = dst_ok ? OP_OR    : OP_NOP;
        4'd5: ctrl.op = dst_ok ? OP_XOR   : OP_NOP;
        4'd6: ctrl.op = dst_ok ? OP_SHIFT : OP_NOP;
        4'd7: ctrl.op = OP_FLAGLD;
        4'd8: ctrl.op = OP_SETALL;
        default: ctrl.op = OP_NOP;
      endcase
    end
  end
endmodule

// File: rtl/bpg_cell.sv
module bpg_cell
  import bpg_pkg::*;
#(
  parameter int NREG = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrl_t            ctrl,
  input  logic [3:0]       nbr,
  input  logic             ld_we,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic             ld_bit,
  output logic [NREG-1:0]  regs_q,
  output logic             flag_q,
  output logic             src_out
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NREG - 1);

  logic            op_a;
  logic            op_b;
  logic            res;
  logic            wr_en;
  logic            regs_en;
  logic [NREG-1:0] regs_d;
  logic            flag_en;
  logic            flag_d;

  assign op_a    = (ctrl.src_a <= LAST) ? regs_q[ctrl.src_a] : 1'b0;
  assign op_b    = (ctrl.src_b <= LAST) ? regs_q[ctrl.src_b] : 1'b0;
  assign src_out = op_a;

  // operation result and masked write enable
  always_comb begin
    res   = 1'b0;
    wr_en = 1'b0;
    case (ctrl.op)
      OP_COPY:  begin res = op_a;          wr_en = flag_q; end
      OP_NOT:   begin res = ~op_a;         wr_en = flag_q; end
      OP_AND:   begin res = op_a & op_b;   wr_en = flag_q; end
      OP_OR:    begin res = op_a | op_b;   wr_en = flag_q; end
      OP_XOR:   begin res = op_a ^ op_b;   wr_en = flag_q; end
      OP_SHIFT: begin res = nbr[ctrl.dir]; wr_en = flag_q; end
      default:  begin res = 1'b0;          wr_en = 1'b0;   end
    endcase
  end

  // next register bank: load overrides the broadcast write
  always_comb begin
    regs_d = regs_q;
    if (wr_en) regs_d[ctrl.dst] = res;
    if (ld_we) regs_d[ld_idx] = ld_bit;
  end

  assign regs_en = wr_en | ld_we;
  assign flag_en = (ctrl.op == OP_SETALL) | ((ctrl.op == OP_FLAGLD) & flag_q);
  assign flag_d  = (ctrl.op == OP_SETALL) ? 1'b1 : op_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q <= '0;
    end else if (regs_en) begin
      regs_q <= regs_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b1;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end
endmodule

// File: rtl/bitplane_grid.sv
module bitplane_grid
  import bpg_pkg::*;
#(
  parameter int ROWS = 16,
  parameter int COLS = 16,
  parameter int NREG = 13,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid,
  input  logic [INSTR_W-1:0] instr,
  input  logic               load_en,
  input  logic [ROW_W-1:0]   load_row,
  input  logic [IDX_W-1:0]   load_reg,
  input  logic [COLS-1:0]    load_data,
  input  logic [IDX_W-1:0]   rd_reg,
  input  logic [ROW_W-1:0]   rd_row,
  output logic [COLS-1:0]    rd_data
);
  localparam logic [IDX_W-1:0] LAST     = IDX_W'(NREG - 1);
  localparam logic [IDX_W-1:0] FLAG_IDX = IDX_W'(NREG);

  logic [1:0]      rst_pipe;
  logic            rst_sync_n;
  ctrl_t           ctrl;
  logic            load_ok;
  logic [NREG-1:0] regs_a [ROWS][COLS];
  logic            flag_a [ROWS][COLS];
  logic            src_a  [ROWS][COLS];

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  bpg_decode #(.NREG(NREG)) u_dec (
    .valid (instr_valid),
    .instr (instr),
    .ctrl  (ctrl)
  );

  assign load_ok = load_en & (load_reg <= LAST);

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      logic [3:0] nbr;

      if (r > 0) begin : g_n
        assign nbr[DIR_N] = src_a[r-1][c];
      end else begin : g_n_edge
        assign nbr[DIR_N] = 1'b0;
      end
      if (r < ROWS - 1) begin : g_s
        assign nbr[DIR_S] = src_a[r+1][c];
      end else begin : g_s_edge
        assign nbr[DIR_S] = 1'b0;
      end
      if (c < COLS - 1) begin : g_e
        assign nbr[DIR_E] = src_a[r][c+1];
      end else begin : g_e_edge
        assign nbr[DIR_E] = 1'b0;
      end
      if (c > 0) begin : g_w
        assign nbr[DIR_W] = src_a[r][c-1];
      end else begin : g_w_edge
        assign nbr[DIR_W] = 1'b0;
      end

      bpg_cell #(.NREG(NREG)) u_cell (
        .clk     (clk),
        .rst_n   (rst_sync_n),
        .ctrl    (ctrl),
        .nbr     (nbr),
        .ld_we   (load_ok && (load_row == ROW_W'(r))),
        .ld_idx  (load_reg),
        .ld_bit  (load_data[c]),
        .regs_q  (regs_a[r][c]),
        .flag_q  (flag_a[r][c]),
        .src_out (src_a[r][c])
      );
    end
  end

  always_comb begin
    for (int c = 0; c < COLS; c++) begin
      rd_data[c] = 1'b0;
      if (rd_reg <= LAST) begin
        rd_data[c] = regs_a[rd_row][c][rd_reg];
      end else if (rd_reg == FLAG_IDX) begin
        rd_data[c] = flag_a[rd_row][c];
      end
    end
  end
endmodule

// File: rtl/bpg_chk.sv
module bpg_chk
  import bpg_pkg::*;
#(
  parameter int COLS  = 16,
  parameter int ROW_W = 4,
  parameter int NREG  = 13
) (
  input logic               clk,
  input logic               rst_n,
  input logic               instr_valid,
  input logic [INSTR_W-1:0] instr,
  input logic               load_en,
  input logic [ROW_W-1:0]   load_row,
  input logic [IDX_W-1:0]   load_reg,
  input logic [COLS-1:0]    load_data,
  input logic [IDX_W-1:0]   rd_reg,
  input logic [ROW_W-1:0]   rd_row,
  input logic [COLS-1:0]    rd_data
);
  localparam logic [IDX_W-1:0] LAST     = IDX_W'(NREG - 1);
  localparam logic [IDX_W-1:0] FLAG_IDX = IDX_W'(NREG);

  AST_LOAD_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && load_reg <= LAST) |=>
      (rd_reg != $past(load_reg) || rd_row != $past(load_row) || rd_data == $past(load_data))); // R2

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_reg > FLAG_IDX) |-> (rd_data == '0)); // R3

  AST_SETALL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr[17:14] == 4'd8) |=> (rd_reg != FLAG_IDX || rd_data == '1)); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && (!instr_valid || instr[17:14] == 4'd0 || instr[17:14] > 4'd8)) |=>
      (!$stable(rd_reg) || !$stable(rd_row) || $stable(rd_data))); // R10
endmodule

bind bitplane_grid bpg_chk #(.COLS(COLS), .ROW_W(ROW_W), .NREG(NREG)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .instr_valid (instr_valid),
  .instr       (instr),
  .load_en     (load_en),
  .load_row    (load_row),
  .load_reg    (load_reg),
  .load_data   (load_data),
  .rd_reg      (rd_reg),
  .rd_row      (rd_row),
  .rd_data     (rd_data)
);

// File: tb/bitplane_grid_test.sv
module bitplane_grid_test;
  localparam int ROWS = 16;
  localparam int COLS = 16;
  localparam int NREG = 13;

  logic        clk;
  logic        rst_n;
  logic        instr_valid;
  logic [17:0] instr;
  logic        load_en;
  logic [3:0]  load_row;
  logic [3:0]  load_reg;
  logic [15:0] load_data;
  logic [3:0]  rd_reg;
  logic [3:0]  rd_row;
  logic [15:0] rd_data;

  int checks = 0;
  int fails  = 0;

  bit mr [ROWS][COLS][NREG];
  bit mf [ROWS][COLS];

  bitplane_grid #(.ROWS(ROWS), .COLS(COLS), .NREG(NREG)) uut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .load_en(load_en), .load_row(load_row), .load_reg(load_reg), .load_data(load_data),
    .rd_reg(rd_reg), .rd_row(rd_row), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [17:0] mk(int op, int dst, int sa, int sb, int dir);
    return {op[3:0], dst[3:0], sa[3:0], sb[3:0], dir[1:0]};
  endfunction

  function automatic logic [15:0] pat(int r, int k);
    logic [15:0] p;
    p = 16'(r * 16'h1357) ^ 16'hA55A;
    if (k == 1) p = {p[7:0], p[15:8]} ^ 16'h0FF0;
    return p;
  endfunction

  function automatic logic [15:0] exp_row(int p, int r);
    logic [15:0] v;
    v = '0;
    for (int c = 0; c < COLS; c++) begin
      if (p < NREG) v[c] = mr[r][c][p];
      else if (p == NREG) v[c] = mf[r][c];
    end
    return v;
  endfunction

  // behavioural model of one clock edge
  task automatic model_edge(logic v, logic [17:0] ins, logic le, int lrow, int lreg, logic [15:0] ld);
    bit or_ [ROWS][COLS][NREG];
    bit of_ [ROWS][COLS];
    int op, dst, sa, sb, dir;
    op = int'(ins[17:14]); dst = int'(ins[13:10]); sa = int'(ins[9:6]);
    sb = int'(ins[5:2]);   dir = int'(ins[1:0]);
    or_ = mr; of_ = mf;
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        bit a, b, res;
        int nr, nc;
        a = (sa < NREG) ? or_[r][c][sa] : 1'b0;
        b = (sb < NREG) ? or_[r][c][sb] : 1'b0;
        nr = r; nc = c;
        if (dir == 0) nr = r - 1;
        else if (dir == 1) nr = r + 1;
        else if (dir == 2) nc = c + 1;
        else nc = c - 1;
        res = 1'b0;
        case (op)
          1: res = a;
          2: res = ~a;
          3: res = a & b;
          4: res = a | b;
          5: res = a ^ b;
          6: res = (nr < 0 || nr >= ROWS || nc < 0 || nc >= COLS) ? 1'b0 :
                   ((sa < NREG) ? or_[nr][nc][sa] : 1'b0);
          default: res = 1'b0;
        endcase
        if (v && op >= 1 && op <= 6 && dst < NREG && of_[r][c]) mr[r][c][dst] = res;
        if (v && op == 7 && of_[r][c]) mf[r][c] = a;
        if (v && op == 8) mf[r][c] = 1'b1;
        if (le && lrow == r && lreg < NREG) mr[r][c][lreg] = ld[c];
      end
    end
  endtask

  // walk the read port over every plane and row; state is idle meanwhile
  task automatic sweep(string req);
    for (int p = 0; p < 16; p++) begin
      bit bad;
      bad = 1'b0;
      for (int r = 0; r < ROWS; r++) begin
        rd_reg = 4'(p);
        rd_row = 4'(r);
        #1;
        if (!bad && rd_data !== exp_row(p, r)) begin
          bad = 1'b1;
          $display("FAIL %s plane %0d row %0d: actual %h expected %h", req, p, r, rd_data, exp_row(p, r));
        end
      end
      checks++;
      if (bad) fails++;
    end
  endtask

  task automatic step(logic v, logic [17:0] ins, logic le, int lrow, int lreg, logic [15:0] ld, string req);
    instr_valid = v; instr = ins; load_en = le;
    load_row = 4'(lrow); load_reg = 4'(lreg); load_data = ld;
    @(posedge clk);
    model_edge(v, ins, le, lrow, lreg, ld);
    #1;
    instr_valid = 1'b0; instr = '0; load_en = 1'b0;
    sweep(req);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #4000000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; instr_valid = 1'b0; instr = '0; load_en = 1'b0;
    load_row = '0; load_reg = '0; load_data = '0; rd_reg = '0; rd_row = '0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        mf[r][c] = 1'b1;
        for (int k = 0; k < NREG; k++) mr[r][c][k] = 1'b0;
      end
    repeat (3) @(posedge clk);
    #2;
    sweep("R1");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    sweep("R1");
    @(negedge clk);

    // R2: fill planes 0 and 1 row by row
    for (int r = 0; r < ROWS; r++) step(1'b0, '0, 1'b1, r, 0, pat(r, 0), "R2");
    for (int r = 0; r < ROWS; r++) step(1'b0, '0, 1'b1, r, 1, pat(r, 1), "R2");
    step(1'b1, mk(1, 2, 0, 0, 0), 1'b1, 5, 2, 16'hFFFF, "R2");
    step(1'b0, '0, 1'b1, 3, 13, 16'h0000, "R2");
    sweep("R3");
    @(negedge clk);

    // R4: Boolean operations
    step(1'b1, mk(1, 3, 0, 0, 0), 1'b0, 0, 0, '0, "R4");
    step(1'b1, mk(2, 4, 1, 0, 0), 1'b0, 0, 0, '0, "R4");
    step(1'b1, mk(3, 5, 0, 1, 0), 1'b0, 0, 0, '0, "R4");
    step(1'b1, mk(4, 6, 0, 1, 0), 1'b0, 0, 0, '0, "R4");
    step(1'b1, mk(5, 7, 0, 1, 0), 1'b0, 0, 0, '0, "R4");

    // R5: neighbour copies in every direction
    step(1'b1, mk(6, 8, 0, 0, 0), 1'b0, 0, 0, '0, "R5");
    step(1'b1, mk(6, 9, 0, 0, 1), 1'b0, 0, 0, '0, "R5");
    step(1'b1, mk(6, 10, 1, 0, 2), 1'b0, 0, 0, '0, "R5");
    step(1'b1, mk(6, 11, 1, 0, 3), 1'b0, 0, 0, '0, "R5");

    // R6: in-place shifts move one element per instruction
    step(1'b1, mk(6, 3, 3, 0, 2), 1'b0, 0, 0, '0, "R6");
    step(1'b1, mk(6, 3, 3, 0, 2), 1'b0, 0, 0, '0, "R6");
    step(1'b1, mk(6, 4, 4, 0, 1), 1'b0, 0, 0, '0, "R6");

    // R8 / R7: conditional execution
    step(1'b1, mk(7, 0, 1, 0, 0), 1'b0, 0, 0, '0, "R8");
    step(1'b1, mk(3, 12, 0, 1, 0), 1'b0, 0, 0, '0, "R7");
    step(1'b1, mk(2, 0, 0, 0, 0), 1'b0, 0, 0, '0, "R7");
    step(1'b1, mk(6, 5, 5, 0, 0), 1'b0, 0, 0, '0, "R7");
    step(1'b1, mk(7, 0, 0, 0, 0), 1'b0, 0, 0, '0, "R8");
    step(1'b1, mk(1, 2, 6, 0, 0), 1'b0, 0, 0, '0, "R7");

    // R9: global flag set
    step(1'b1, mk(8, 7, 3, 2, 1), 1'b0, 0, 0, '0, "R9");
    step(1'b1, mk(1, 12, 4, 0, 0), 1'b0, 0, 0, '0, "R9");

    // R10: instructions with no effect
    step(1'b0, mk(2, 0, 0, 0, 0), 1'b0, 0, 0, '0, "R10");
    step(1'b1, mk(9, 0, 1, 1, 0), 1'b0, 0, 0, '0, "R10");
    step(1'b1, mk(15, 1, 0, 0, 0), 1'b0, 0, 0, '0, "R10");
    step(1'b1, mk(1, 13, 0, 0, 0), 1'b0, 0, 0, '0, "R10");
    step(1'b1, mk(2, 14, 0, 0, 0), 1'b0, 0, 0, '0, "R10");
    step(1'b1, mk(0, 3, 0, 0, 0), 1'b0, 0, 0, '0, "R10");

    summary();
    $finish;
  end
endmodule